// File: doc/BRIEF.md
# Switch Reduction Slot Engine

This block sits in a switch dataplane and folds collective-operation packets into partial results held in a small set of on-chip accumulator slots. Each accepted packet names a group, a reduction operation, the index of the contributor that sent it and a vector of signed integer lanes. The group number is hashed onto a slot, so the slot array acts as a small cache of active groups rather than a table covering every group. The packet is then either merged into that slot's partial, loaded as the first contribution, turned away as a collision, dropped as an operation mismatch, or acknowledged as a repeat.

Each slot keeps a bitmap with one bit per contributor. A retransmitted packet therefore never counts twice. Once the number of distinct contributors reaches the configured threshold, the finished vector is presented on a result port for replication to the members, and the slot is released. The way a released slot is cleared is set at build time. Eager wiping, alternating banks and deferred clearing all give the same behaviour at the ports.

Top module: `agg_engine`

## Requirements
- R1: The slot index is the XOR of the group number cut into SLOT_W-bit chunks, starting from the low chunk. With the default sizes, groups 0x00 and 0x05 share slot 0 and group 0x01 uses slot 1.
- R2: A packet that lands on a free slot loads its payload unchanged as the partial. Whatever a previously released group left in that slot is ignored.
- R3: The sum operation adds each 32-bit two's-complement lane and clamps the result to 0x7FFFFFFF on positive overflow and to 0x80000000 on negative overflow.
- R4: Operation code 0 is sum, 1 is signed maximum and 2 is signed minimum. Each is applied per lane, and code 3 also sums.
- R5: When a packet's contributor bit is already set in its slot, the packet leaves the partial and the count unchanged, and `dup_o` is high for the one cycle after it is accepted.
- R6: The group completes when its count of distinct contributors reaches `cfg_thresh_i`, with a threshold of 0 treated as 1. The result and the group number then appear on the result port in the cycle after the completing packet is accepted, and the slot becomes free.
- R7: A packet whose slot is held by another group is presented unmodified on the fallback port in the cycle after it is accepted, and `coll_cnt_o` goes up by one.
- R8: A packet for a held group whose operation code differs from the stored one is dropped without touching the slot, and `err_o` is high for the one cycle after it is accepted.
- R9: `in_ready_o` is low while a result or a fallback packet is pending. A pending output keeps its value until its ready is high.
- R10: The three clear policies (0 wipe, 1 alternating banks, 2 deferred) give identical port behaviour cycle by cycle for identical stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_thresh_i | input | $clog2(NCONTRIB+1) | Contributors needed to complete a group |
| in_valid_i | input | 1 | Packet valid |
| in_ready_o | output | 1 | Packet accepted when high with valid |
| in_gid_i | input | GID_W | Group number |
| in_op_i | input | 2 | Operation code |
| in_src_i | input | $clog2(NCONTRIB) | Contributor index |
| in_data_i | input | LANES*LANE_W | Payload lanes |
| res_valid_o | output | 1 | Result pending |
| res_ready_i | input | 1 | Result taken |
| res_gid_o | output | GID_W | Group of the result |
| res_data_o | output | LANES*LANE_W | Finished vector |
| fb_valid_o | output | 1 | Fallback packet pending |
| fb_ready_i | input | 1 | Fallback packet taken |
| fb_gid_o | output | GID_W | Fallback group |
| fb_op_o | output | 2 | Fallback operation code |
| fb_src_o | output | $clog2(NCONTRIB) | Fallback contributor |
| fb_data_o | output | LANES*LANE_W | Fallback payload |
| dup_o | output | 1 | Repeat acknowledged, one-cycle pulse |
| err_o | output | 1 | Operation mismatch, one-cycle pulse |
| coll_cnt_o | output | CCNT_W | Collision count |

## Verification
The bench uses the default sizes: four 32-bit lanes, four slots, four contributors and an 8-bit group number. At these sizes every threshold from 0 to 4, every operation code and every arrival order of contributors can be swept with lane values placed next to both saturation limits. Three copies are built, one per clear policy, and share the same stimulus. Their outputs are compared every cycle, and the deferred-clear copy then reuses slots that still hold stale partials from earlier groups. With four slots, colliding and non-colliding group pairs are easy to pick by hand.

// File: rtl/agg_pkg.sv
package agg_pkg;
  typedef logic [1:0] op_t;
  localparam op_t OP_SUM = 2'd0;
  localparam op_t OP_MAX = 2'd1;
  localparam op_t OP_MIN = 2'd2;
  localparam int CLR_COPY   = 0;
  localparam int CLR_SHADOW = 1;
  localparam int CLR_LAZY   = 2;
endpackage

// File: rtl/agg_hash.sv
module agg_hash #(
  parameter int GID_W  = 8,
  parameter int SLOT_W = 2
) (
  input  logic [GID_W-1:0]  gid_i,
  output logic [SLOT_W-1:0] idx_o
);
  localparam int CHUNKS = (GID_W + SLOT_W - 1) / SLOT_W;
  localparam int EXT_W  = CHUNKS * SLOT_W;

  logic [EXT_W-1:0] ext;

  always_comb begin
    ext = '0;
    ext[GID_W-1:0] = gid_i;
    idx_o = '0;
    for (int c = 0; c < CHUNKS; c++) idx_o = idx_o ^ ext[c*SLOT_W +: SLOT_W];
  end
endmodule

// File: rtl/agg_lane_alu.sv
module agg_lane_alu import agg_pkg::*; #(
  parameter int W = 32
) (
  input  op_t          op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [W:0] sum;
  logic       a_gt;

  assign sum  = {a_i[W-1], a_i} + {b_i[W-1], b_i};
  assign a_gt = $signed(a_i) > $signed(b_i);

  always_comb begin
    case (op_i)
      OP_MAX:  y_o = a_gt ? a_i : b_i;
      OP_MIN:  y_o = a_gt ? b_i : a_i;
      default: begin
        // overflow when the two top bits of the widened sum disagree
        if (sum[W] != sum[W-1]) y_o = sum[W] ? SMIN : SMAX;
        else                    y_o = sum[W-1:0];
      end
    endcase
  end
endmodule

// File: rtl/agg_engine.sv
module agg_engine import agg_pkg::*; #(
  parameter int LANES      = 4,
  parameter int LANE_W     = 32,
  parameter int SLOTS      = 4,
  parameter int GID_W      = 8,
  parameter int NCONTRIB   = 4,
  parameter int CCNT_W     = 16,
  parameter int CLEAR_MODE = CLR_LAZY
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [$clog2(NCONTRIB+1)-1:0] cfg_thresh_i,
  input  logic                          in_valid_i,
  output logic                          in_ready_o,
  input  logic [GID_W-1:0]              in_gid_i,
  input  logic [1:0]                    in_op_i,
  input  logic [$clog2(NCONTRIB)-1:0]   in_src_i,
  input  logic [LANES*LANE_W-1:0]       in_data_i,
  output logic                          res_valid_o,
  input  logic                          res_ready_i,
  output logic [GID_W-1:0]              res_gid_o,
  output logic [LANES*LANE_W-1:0]       res_data_o,
  output logic                          fb_valid_o,
  input  logic                          fb_ready_i,
  output logic [GID_W-1:0]              fb_gid_o,
  output logic [1:0]                    fb_op_o,
  output logic [$clog2(NCONTRIB)-1:0]   fb_src_o,
  output logic [LANES*LANE_W-1:0]       fb_data_o,
  output logic                          dup_o,
  output logic                          err_o,
  output logic [CCNT_W-1:0]             coll_cnt_o
);
  localparam int  DATA_W = LANES * LANE_W;
  localparam int  SLOT_W = $clog2(SLOTS);
  localparam int  SRC_W  = $clog2(NCONTRIB);
  localparam int  CNT_W  = $clog2(NCONTRIB + 1);
  localparam bit  WIPE   = (CLEAR_MODE == CLR_COPY);
  localparam bit  FLIP   = (CLEAR_MODE == CLR_SHADOW);

  // slot state
  logic [SLOTS-1:0]    occ_q;
  logic [SLOTS-1:0]    bank_q;
  logic [GID_W-1:0]    gid_q [SLOTS];
  op_t                 op_q  [SLOTS];
  logic [NCONTRIB-1:0] bm_q  [SLOTS];
  logic [DATA_W-1:0]   acc_q [SLOTS][2];

  // output state
  logic                res_valid_q, fb_valid_q, dup_q, err_q;
  logic [GID_W-1:0]    res_gid_q, fb_gid_q;
  logic [DATA_W-1:0]   res_data_q, fb_data_q;
  op_t                 fb_op_q;
  logic [SRC_W-1:0]    fb_src_q;
  logic [CCNT_W-1:0]   coll_q;

  logic [SLOT_W-1:0]   idx;
  logic                bsel;
  logic [DATA_W-1:0]   acc_rd, mrg, new_acc;
  logic [NCONTRIB-1:0] src_oh, new_bm;
  logic [CNT_W-1:0]    cnt, thr_eff;
  logic                take, hit, is_new, is_coll, is_err, is_dup, is_upd, done;

  agg_hash #(.GID_W(GID_W), .SLOT_W(SLOT_W)) u_hash (
    .gid_i (in_gid_i),
    .idx_o (idx)
  );

  assign bsel   = bank_q[idx];
  assign acc_rd = acc_q[idx][bsel];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    agg_lane_alu #(.W(LANE_W)) u_alu (
      .op_i (in_op_i),
      .a_i  (acc_rd[g*LANE_W +: LANE_W]),
      .b_i  (in_data_i[g*LANE_W +: LANE_W]),
      .y_o  (mrg[g*LANE_W +: LANE_W])
    );
  end

  assign in_ready_o = !res_valid_q && !fb_valid_q;
  assign take       = in_valid_i && in_ready_o;
  assign hit        = occ_q[idx] && (gid_q[idx] == in_gid_i);
  assign is_new     = !occ_q[idx];
  assign is_coll    = occ_q[idx] && !hit;
  assign is_err     = hit && (op_q[idx] != in_op_i);
  assign is_dup     = hit && !is_err && bm_q[idx][in_src_i];
  assign is_upd     = is_new || (hit && !is_err && !is_dup);
  assign thr_eff    = (cfg_thresh_i == '0) ? CNT_W'(1) : cfg_thresh_i;

  always_comb begin
    src_oh = '0;
    src_oh[in_src_i] = 1'b1;
    new_bm  = is_new ? src_oh : (bm_q[idx] | src_oh);
    new_acc = is_new ? in_data_i : mrg;
    cnt = '0;
    for (int i = 0; i < NCONTRIB; i++) cnt = cnt + CNT_W'(new_bm[i]);
  end

  assign done = cnt >= thr_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q       <= '0;
      bank_q      <= '0;
      res_valid_q <= 1'b0;
      fb_valid_q  <= 1'b0;
      dup_q       <= 1'b0;
      err_q       <= 1'b0;
      res_gid_q   <= '0;
      res_data_q  <= '0;
      fb_gid_q    <= '0;
      fb_data_q   <= '0;
      fb_op_q     <= '0;
      fb_src_q    <= '0;
      coll_q      <= '0;
      for (int s = 0; s < SLOTS; s++) begin
        gid_q[s]    <= '0;
        op_q[s]     <= '0;
        bm_q[s]     <= '0;
        acc_q[s][0] <= '0;
        acc_q[s][1] <= '0;
      end
    end else begin
      dup_q <= take && is_dup;
      err_q <= take && is_err;
      if (res_valid_q && res_ready_i) res_valid_q <= 1'b0;
      if (fb_valid_q && fb_ready_i)   fb_valid_q  <= 1'b0;
      if (take && is_coll) begin
        fb_valid_q <= 1'b1;
        fb_gid_q   <= in_gid_i;
        fb_op_q    <= in_op_i;
        fb_src_q   <= in_src_i;
        fb_data_q  <= in_data_i;
        coll_q     <= coll_q + 1'b1;
      end
      if (take && is_upd) begin
        if (done) begin
          res_valid_q <= 1'b1;
          res_gid_q   <= in_gid_i;
          res_data_q  <= new_acc;
          occ_q[idx]  <= 1'b0;
          if (WIPE) begin
            bm_q[idx]        <= '0;
            acc_q[idx][bsel] <= '0;
          end
          if (FLIP) begin
            // finished bank is left as is; the other one becomes active
            bm_q[idx]         <= '0;
            bank_q[idx]       <= !bsel;
            acc_q[idx][!bsel] <= '0;
          end
        end else begin
          occ_q[idx]       <= 1'b1;
          gid_q[idx]       <= in_gid_i;
          op_q[idx]        <= in_op_i;
          bm_q[idx]        <= new_bm;
          acc_q[idx][bsel] <= new_acc;
        end
      end
    end
  end

  assign res_valid_o = res_valid_q;
  assign res_gid_o   = res_gid_q;
  assign res_data_o  = res_data_q;
  assign fb_valid_o  = fb_valid_q;
  assign fb_gid_o    = fb_gid_q;
  assign fb_op_o     = fb_op_q;
  assign fb_src_o    = fb_src_q;
  assign fb_data_o   = fb_data_q;
  assign dup_o       = dup_q;
  assign err_o       = err_q;
  assign coll_cnt_o  = coll_q;
endmodule

// File: rtl/agg_engine_chk.sv
module agg_engine_chk #(
  parameter int DATA_W = 128,
  parameter int GID_W  = 8,
  parameter int CCNT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_ready_o,
  input logic              res_valid_o,
  input logic              res_ready_i,
  input logic [GID_W-1:0]  res_gid_o,
  input logic [DATA_W-1:0] res_data_o,
  input logic              fb_valid_o,
  input logic              fb_ready_i,
  input logic [DATA_W-1:0] fb_data_o,
  input logic              dup_o,
  input logic              err_o,
  input logic [CCNT_W-1:0] coll_cnt_o
);
  assert_res_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !res_ready_i |=> res_valid_o && $stable(res_data_o) && $stable(res_gid_o));

  assert_fb_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_valid_o && !fb_ready_i |=> fb_valid_o && $stable(fb_data_o));

  assert_single_out_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(res_valid_o && fb_valid_o));

  assert_coll_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coll_cnt_o != $past(coll_cnt_o)) |-> $rose(fb_valid_o));

  assert_dup_no_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dup_o |-> !$rose(res_valid_o) && !err_o);

  assert_err_no_effect_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !$rose(res_valid_o) && !$rose(fb_valid_o));

  assert_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(res_valid_o) |-> !in_ready_o);
endmodule

bind agg_engine agg_engine_chk #(
  .DATA_W (LANES*LANE_W),
  .GID_W  (GID_W),
  .CCNT_W (CCNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_ready_o  (in_ready_o),
  .res_valid_o (res_valid_o),
  .res_ready_i (res_ready_i),
  .res_gid_o   (res_gid_o),
  .res_data_o  (res_data_o),
  .fb_valid_o  (fb_valid_o),
  .fb_ready_i  (fb_ready_i),
  .fb_data_o   (fb_data_o),
  .dup_o       (dup_o),
  .err_o       (err_o),
  .coll_cnt_o  (coll_cnt_o)
);

// File: tb/sim_agg_engine.sv
`timescale 1ns/1ps
module sim_agg_engine;
  localparam int NI = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   thr = 3'd4;
  logic         in_valid = 1'b0;
  logic [7:0]   in_gid = '0;
  logic [1:0]   in_op = '0;
  logic [1:0]   in_src = '0;
  logic [127:0] in_data = '0;
  logic         res_ready = 1'b0;
  logic         fb_ready = 1'b0;

  logic         in_ready [NI];
  logic         res_valid [NI];
  logic [7:0]   res_gid [NI];
  logic [127:0] res_data [NI];
  logic         fb_valid [NI];
  logic [7:0]   fb_gid [NI];
  logic [1:0]   fb_op [NI];
  logic [1:0]   fb_src [NI];
  logic [127:0] fb_data [NI];
  logic         dup [NI];
  logic         err [NI];
  logic [15:0]  coll [NI];

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  agg_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_thresh_i(thr),
    .in_valid_i(in_valid), .in_ready_o(in_ready[0]), .in_gid_i(in_gid), .in_op_i(in_op),
    .in_src_i(in_src), .in_data_i(in_data),
    .res_valid_o(res_valid[0]), .res_ready_i(res_ready), .res_gid_o(res_gid[0]), .res_data_o(res_data[0]),
    .fb_valid_o(fb_valid[0]), .fb_ready_i(fb_ready), .fb_gid_o(fb_gid[0]), .fb_op_o(fb_op[0]),
    .fb_src_o(fb_src[0]), .fb_data_o(fb_data[0]),
    .dup_o(dup[0]), .err_o(err[0]), .coll_cnt_o(coll[0])
  );

  agg_engine #(.CLEAR_MODE(0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_thresh_i(thr),
    .in_valid_i(in_valid), .in_ready_o(in_ready[1]), .in_gid_i(in_gid), .in_op_i(in_op),
    .in_src_i(in_src), .in_data_i(in_data),
    .res_valid_o(res_valid[1]), .res_ready_i(res_ready), .res_gid_o(res_gid[1]), .res_data_o(res_data[1]),
    .fb_valid_o(fb_valid[1]), .fb_ready_i(fb_ready), .fb_gid_o(fb_gid[1]), .fb_op_o(fb_op[1]),
    .fb_src_o(fb_src[1]), .fb_data_o(fb_data[1]),
    .dup_o(dup[1]), .err_o(err[1]), .coll_cnt_o(coll[1])
  );

  agg_engine #(.CLEAR_MODE(1)) u2 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_thresh_i(thr),
    .in_valid_i(in_valid), .in_ready_o(in_ready[2]), .in_gid_i(in_gid), .in_op_i(in_op),
    .in_src_i(in_src), .in_data_i(in_data),
    .res_valid_o(res_valid[2]), .res_ready_i(res_ready), .res_gid_o(res_gid[2]), .res_data_o(res_data[2]),
    .fb_valid_o(fb_valid[2]), .fb_ready_i(fb_ready), .fb_gid_o(fb_gid[2]), .fb_op_o(fb_op[2]),
    .fb_src_o(fb_src[2]), .fb_data_o(fb_data[2]),
    .dup_o(dup[2]), .err_o(err[2]), .coll_cnt_o(coll[2])
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // R10: all clear policies agree at the ports every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 1; i < NI; i++) begin
        check("R10", {res_valid[i], res_gid[i], fb_valid[i], dup[i], err[i], in_ready[i], coll[i]},
                     {res_valid[0], res_gid[0], fb_valid[0], dup[0], err[0], in_ready[0], coll[0]});
        check("R10", res_data[i], res_data[0]);
        check("R10", fb_data[i], fb_data[0]);
      end
    end
  end

  function automatic logic [31:0] lane_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    longint s;
    case (op)
      2'd1: return ($signed(a) > $signed(b)) ? a : b;
      2'd2: return ($signed(a) < $signed(b)) ? a : b;
      default: begin
        s = longint'($signed(a)) + longint'($signed(b));
        if (s > 64'sd2147483647)  return 32'h7fff_ffff;
        if (s < -64'sd2147483648) return 32'h8000_0000;
        return s[31:0];
      end
    endcase
  endfunction

  function automatic logic [127:0] vec_op(input logic [1:0] op, input logic [127:0] a, input logic [127:0] b);
    logic [127:0] r;
    for (int l = 0; l < 4; l++) r[l*32 +: 32] = lane_op(op, a[l*32 +: 32], b[l*32 +: 32]);
    return r;
  endfunction

  function automatic logic [127:0] pat(input int p, input int k);
    logic [127:0] r;
    for (int l = 0; l < 4; l++) begin
      case (p)
        0: r[l*32 +: 32] = 32'(k*100 + l*7 + 1);
        1: r[l*32 +: 32] = 32'(l*13 - k*50 - 20);
        2: r[l*32 +: 32] = 32'h7fff_ff00 + 32'(k*64 + l);
        default: r[l*32 +: 32] = 32'h8000_0100 - 32'(k*96 + l);
      endcase
    end
    return r;
  endfunction

  task automatic send(input logic [7:0] g, input logic [1:0] op, input logic [1:0] s, input logic [127:0] d);
    @(negedge clk);
    in_gid = g; in_op = op; in_src = s; in_data = d; in_valid = 1'b1;
    while (!in_ready[0]) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic take_res(input string req, input logic [7:0] g, input logic [127:0] d);
    check(req, {127'd0, res_valid[0]}, 128'd1);
    check(req, {120'd0, res_gid[0]}, {120'd0, g});
    check(req, res_data[0], d);
    res_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] exp;
    logic [127:0] d;
    logic [15:0]  c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset", {123'd0, res_valid[0], fb_valid[0], dup[0], err[0], in_ready[0]}, 128'd1);
    check("R7 reset", {112'd0, coll[0]}, 128'd0);

    // sweep: op x threshold x pattern, contributors in permuted order
    for (int op = 0; op < 4; op++) begin
      for (int t = 0; t < 5; t++) begin
        for (int p = 0; p < 4; p++) begin
          int n;
          logic [7:0] g;
          n = (t == 0) ? 1 : t;
          g = 8'(op*40 + t*8 + p);
          thr = 3'(t);
          for (int k = 0; k < n; k++) begin
            logic [1:0] s;
            s = 2'((k*3 + p) % 4);
            d = pat(p, k);
            exp = (k == 0) ? d : vec_op(2'(op), exp, d);
            send(g, 2'(op), s, d);
            if (k < n - 1) check("R6 early", {127'd0, res_valid[0]}, 128'd0);
          end
          // R2 R3 R4 R6: fold computed in the bench
          take_res((p >= 2) ? "R3" : ((op != 0) ? "R4" : "R2"), g, exp);
        end
      end
    end

    // R5: repeated contributor is acknowledged, not merged
    thr = 3'd3;
    send(8'h11, 2'd0, 2'd0, pat(0, 1));
    send(8'h11, 2'd0, 2'd1, pat(0, 2));
    check("R5 first", {127'd0, dup[0]}, 128'd0);
    send(8'h11, 2'd0, 2'd1, pat(0, 3));
    check("R5 pulse", {126'd0, dup[0], res_valid[0]}, 128'd2);
    @(negedge clk);
    check("R5 width", {127'd0, dup[0]}, 128'd0);
    send(8'h11, 2'd0, 2'd3, pat(0, 4));
    take_res("R5", 8'h11, vec_op(2'd0, vec_op(2'd0, pat(0, 1), pat(0, 2)), pat(0, 4)));

    // R8: mismatched operation dropped
    send(8'h22, 2'd0, 2'd0, pat(1, 1));
    send(8'h22, 2'd1, 2'd1, pat(1, 2));
    check("R8 pulse", {126'd0, err[0], res_valid[0]}, 128'd2);
    send(8'h22, 2'd0, 2'd1, pat(1, 3));
    check("R8 width", {127'd0, err[0]}, 128'd0);
    send(8'h22, 2'd0, 2'd2, pat(1, 4));
    take_res("R8", 8'h22, vec_op(2'd0, vec_op(2'd0, pat(1, 1), pat(1, 3)), pat(1, 4)));

    // R1 R7: 0x05 collides with 0x00, 0x01 does not
    thr = 3'd2;
    c0 = coll[0];
    send(8'h00, 2'd1, 2'd0, pat(0, 5));
    send(8'h01, 2'd2, 2'd0, pat(1, 5));
    check("R1 no collision", {111'd0, fb_valid[0], coll[0]}, {112'd0, c0});
    send(8'h05, 2'd0, 2'd1, pat(2, 5));
    check("R7 fb valid", {126'd0, fb_valid[0], in_ready[0]}, 128'd2);
    check("R7 fb fields", {116'd0, fb_gid[0], fb_op[0], fb_src[0]}, {116'd0, 8'h05, 2'd0, 2'd1});
    check("R7 fb data", fb_data[0], pat(2, 5));
    check("R7 count", {112'd0, coll[0]}, {112'd0, c0 + 16'd1});
    repeat (2) @(negedge clk);
    check("R9 fb hold", {126'd0, fb_valid[0], in_ready[0]}, 128'd2);
    fb_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    fb_ready = 1'b0;
    check("R9 fb drained", {126'd0, fb_valid[0], in_ready[0]}, 128'd1);
    send(8'h00, 2'd1, 2'd2, pat(0, 6));
    // R9: result held under back-pressure
    repeat (3) @(negedge clk);
    check("R9 hold", {126'd0, res_valid[0], in_ready[0]}, 128'd2);
    take_res("R9", 8'h00, vec_op(2'd1, pat(0, 5), pat(0, 6)));
    check("R9 ready", {127'd0, in_ready[0]}, 128'd1);
    send(8'h01, 2'd2, 2'd3, pat(3, 6));
    take_res("R1", 8'h01, vec_op(2'd2, pat(1, 5), pat(3, 6)));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule